// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block is a bus target that stores five one-byte settings for a programmable voltage reference. The settings are a reference level code, a temperature-slope code, a byte that selects the output gain and holds six spare bits, and two bytes of free storage. A bus controller reaches the block over a two-wire serial bus. The block oversamples the clock and data lines with the system clock. It finds START and STOP conditions, matches a 7-bit target address, and then accepts a register pointer followed by data, or returns register contents. It pulls the data line low through an open-drain enable.

Downstream analog control reads the reference code, the slope code and a decoded gain select straight from the ports. A STOP that ends a transfer which stored at least one byte starts a timed persistent-write interval. During that interval `busy` is high and every START is ignored.

Top module: `cfgreg_i2c_target`

## Requirements
- R1: Registers sit at pointer values 0 to 4. `ref_code` always shows register 0 and `slope_code` always shows register 1.
- R2: Bits [1:0] of register 2 drive `gain_sel` as follows: 00 gives 0 (x1), 01 and 10 give 1 (x2), and 11 gives 2 (x4). Bits [7:2] are plain storage and read back exactly as written.
- R3: Every byte moves most significant bit first, in both directions.
- R4: The block answers only the 7-bit address {ADDR_PREFIX, strap_i[2:0]}, with bit 0 of the address byte set to 1 for a read. On any other address SDA stays released, no ACK is given, and the rest of the transfer changes nothing.
- R5: A write transfer is the address byte, then a pointer byte, then data bytes. Each data byte is ACKed, stored at the pointer, and the pointer then moves up by one.
- R6: A pointer byte above 4 gets a NACK. A data byte whose pointer is above 4 gets a NACK and is discarded.
- R7: A read returns the register at the pointer and then moves the pointer up. A pointer above 4 reads as 0xFF. The read ends when the controller NACKs, and SDA is released after that.
- R8: A STOP that ends a transfer which stored data raises `busy` for exactly BUSY_CYCLES clock cycles. A STOP that ends a read, or a write that stored nothing, leaves `busy` low.
- R9: A START seen while `busy` is high is ignored, so the address that follows gets no ACK and nothing is written.
- R10: After reset, SDA is released, every register is 0x00 and `busy` is low.
- R11: `sda_oe` only rises while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, sampled |
| sda_i | input | 1 | Bus data line, sampled |
| sda_oe | output | 1 | When 1, pull the data line low |
| strap_i | input | 3 | Low three address bits from strap pins |
| ref_code | output | 8 | Reference level code (register 0) |
| slope_code | output | 8 | Temperature slope code (register 1) |
| gain_sel | output | 2 | Decoded gain: 0 = x1, 1 = x2, 2 = x4 |
| busy | output | 1 | Persistent-write interval in progress |

## Verification
A change on SCL or SDA reaches the edge detector after the SYNC_STAGES synchronizer flops, and the controller acts on the following edge. An ACK or a data bit therefore appears on `sda_oe` about three clock cycles after SCL falls. The bench drives the bus in quarter periods of six cycles and samples SDA in the middle of each SCL-high phase, well after that latency. The register outputs update in the cycle after the eighth SCL fall of a data byte, so they are checked only after the transfer's STOP. `busy` is counted on every falling clock edge that follows the STOP's SDA rise, which gives the exact length of the interval.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
   localparam int NUM_REGS  = 5;
   localparam int REG_AW    = $clog2(NUM_REGS);
   localparam int IDX_REF   = 0;
   localparam int IDX_SLOPE = 1;
   localparam int IDX_GAIN  = 2;

   typedef enum logic [2:0] {
      PH_IDLE, PH_RX, PH_ACK_OUT, PH_TX, PH_ACK_IN
   } phase_t;

   typedef enum logic [1:0] {
      BK_ADDR, BK_PTR, BK_DATA
   } byte_kind_t;

   // gain code: 0 = x1, 1 = x2, 2 = x4; two raw codes share x2
   function automatic logic [1:0] decode_gain(input logic [1:0] raw);
      case (raw)
         2'b00:   return 2'd0;
         2'b11:   return 2'd2;
         default: return 2'd1;
      endcase
   endfunction
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);
   logic scl_q, sda_q;

   generate
      if (SYNC_STAGES == 0) begin : g_bypass
         assign scl_s = scl_i;
         assign sda_s = sda_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[i] <= 1'b1;
                  sda_chain[i] <= 1'b1;
               end else if (i == 0) begin
                  scl_chain[i] <= scl_i;
                  sda_chain[i] <= sda_i;
               end else begin
                  scl_chain[i] <= scl_chain[(i == 0) ? 0 : i-1];
                  sda_chain[i] <= sda_chain[(i == 0) ? 0 : i-1];
               end
            end
         end
         assign scl_s = scl_chain[SYNC_STAGES-1];
         assign sda_s = sda_chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
   import cfgreg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [7:0]        rd_ptr,
   output logic [7:0]        rd_data,
   output logic [7:0]        ref_code,
   output logic [7:0]        slope_code,
   output logic [1:0]        gain_sel
);
   logic [7:0] regs [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= 8'h00;
      end else if (wr_en) begin
         regs[wr_addr] <= wr_data;
      end
   end

   always_comb begin
      rd_data = 8'hFF;
      for (int i = 0; i < NUM_REGS; i++)
         if (rd_ptr == 8'(i)) rd_data = regs[i];
   end

   assign ref_code   = regs[IDX_REF];
   assign slope_code = regs[IDX_SLOPE];
   assign gain_sel   = decode_gain(regs[IDX_GAIN][1:0]);

   // R1: a write lands at its address one cycle later
   assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> regs[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
   parameter int BUSY_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic commit,
   output logic busy
);
   localparam int CW = $clog2(BUSY_CYCLES + 1);
   logic [CW-1:0] remain;

   generate
      if (BUSY_CYCLES < 1) begin : g_bad_cfg
         $error("busy_timer: BUSY_CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               remain <= '0;
      else if (commit)          remain <= CW'(BUSY_CYCLES);
      else if (remain != '0)    remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);

   // R8: the counter never runs past its load value
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      remain <= CW'(BUSY_CYCLES));
endmodule

// File: rtl/bus_target_ctrl.sv
module bus_target_ctrl
   import cfgreg_pkg::*;
#(
   parameter logic [3:0] ADDR_PREFIX = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_p,
   input  logic              stop_p,
   input  logic [2:0]        strap_i,
   input  logic              busy,
   input  logic [7:0]        rd_data,
   output logic [7:0]        rd_ptr,
   output logic              wr_en,
   output logic [REG_AW-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              commit,
   output logic              sda_oe
);
   phase_t     phase;
   byte_kind_t kind;
   logic [3:0] bit_cnt;
   logic [7:0] shreg, tx, ptr;
   logic       rw, wrote, ctrl_nack, oe_q;

   logic addr_hit, ptr_ok, data_ok, byte_end, ptr_valid;
   assign addr_hit  = (shreg[7:1] == {ADDR_PREFIX, strap_i});
   assign ptr_ok    = (shreg < 8'(NUM_REGS));
   assign ptr_valid = (ptr < 8'(NUM_REGS));
   assign data_ok   = ptr_valid;
   assign byte_end  = (phase == PH_RX) && scl_fall && (bit_cnt == 4'd8);

   assign wr_en   = byte_end && (kind == BK_DATA) && data_ok && !start_p && !stop_p;
   assign wr_addr = ptr[REG_AW-1:0];
   assign wr_data = shreg;
   assign rd_ptr  = ptr;
   assign commit  = stop_p && wrote;
   assign sda_oe  = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         kind      <= BK_ADDR;
         bit_cnt   <= '0;
         shreg     <= '0;
         tx        <= '0;
         ptr       <= '0;
         rw        <= 1'b0;
         wrote     <= 1'b0;
         ctrl_nack <= 1'b0;
         oe_q      <= 1'b0;
      end else if (start_p && !busy) begin
         phase   <= PH_RX;
         kind    <= BK_ADDR;
         bit_cnt <= '0;
         oe_q    <= 1'b0;
      end else if (stop_p) begin
         phase <= PH_IDLE;
         oe_q  <= 1'b0;
         wrote <= 1'b0;
      end else begin
         case (phase)
            PH_RX: begin
               if (scl_rise && bit_cnt < 4'd8) begin
                  shreg   <= {shreg[6:0], sda_s};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (byte_end) begin
                  case (kind)
                     BK_ADDR: begin
                        if (addr_hit) begin
                           rw    <= shreg[0];
                           oe_q  <= 1'b1;
                           phase <= PH_ACK_OUT;
                        end else begin
                           phase <= PH_IDLE;
                        end
                     end
                     BK_PTR: begin
                        ptr   <= shreg;
                        oe_q  <= ptr_ok;
                        phase <= PH_ACK_OUT;
                     end
                     default: begin
                        oe_q <= data_ok;
                        if (data_ok) begin
                           ptr   <= ptr + 8'd1;
                           wrote <= 1'b1;
                        end
                        phase <= PH_ACK_OUT;
                     end
                  endcase
               end
            end
            PH_ACK_OUT: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  if (kind == BK_ADDR && rw) begin
                     tx    <= rd_data;
                     oe_q  <= ~rd_data[7];
                     if (ptr_valid) ptr <= ptr + 8'd1;
                     phase <= PH_TX;
                  end else begin
                     oe_q  <= 1'b0;
                     kind  <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
                     phase <= PH_RX;
                  end
               end
            end
            PH_TX: begin
               if (scl_fall) begin
                  if (bit_cnt == 4'd7) begin
                     oe_q  <= 1'b0;
                     phase <= PH_ACK_IN;
                  end else begin
                     tx      <= {tx[6:0], 1'b1};
                     oe_q    <= ~tx[6];
                     bit_cnt <= bit_cnt + 4'd1;
                  end
               end
            end
            PH_ACK_IN: begin
               if (scl_rise) begin
                  ctrl_nack <= sda_s;
               end else if (scl_fall) begin
                  if (!ctrl_nack) begin
                     bit_cnt <= '0;
                     tx      <= rd_data;
                     oe_q    <= ~rd_data[7];
                     if (ptr_valid) ptr <= ptr + 8'd1;
                     phase   <= PH_TX;
                  end else begin
                     oe_q  <= 1'b0;
                     phase <= PH_IDLE;
                  end
               end
            end
            default: oe_q <= 1'b0;
         endcase
      end
   end

   // R8: a STOP closing a transfer that stored data starts the busy interval
   assert_busy_on_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_p && wrote) |=> busy);
   // R9: a START during the busy interval leaves the controller idle
   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_p && busy && phase == PH_IDLE) |=> phase == PH_IDLE);
   // R10: when idle the data line is released
   assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !oe_q);
   // R11: pulling SDA low starts only while SCL is low
   assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> !scl_s);
endmodule

// File: rtl/cfgreg_i2c_target.sv
module cfgreg_i2c_target
   import cfgreg_pkg::*;
#(
   parameter logic [3:0] ADDR_PREFIX = 4'b1010,
   parameter int          SYNC_STAGES = 2,
   parameter int          BUSY_CYCLES = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [2:0] strap_i,
   output logic [7:0] ref_code,
   output logic [7:0] slope_code,
   output logic [1:0] gain_sel,
   output logic       busy
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("cfgreg_i2c_target: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
   logic wr_en, commit;
   logic [REG_AW-1:0] wr_addr;
   logic [7:0] wr_data, rd_data, rd_ptr;

   bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p));

   bus_target_ctrl #(.ADDR_PREFIX(ADDR_PREFIX)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
      .strap_i(strap_i), .busy(busy), .rd_data(rd_data), .rd_ptr(rd_ptr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit),
      .sda_oe(sda_oe));

   cfg_reg_bank u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_ptr(rd_ptr), .rd_data(rd_data), .ref_code(ref_code),
      .slope_code(slope_code), .gain_sel(gain_sel));

   busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .commit(commit), .busy(busy));
endmodule

// File: tb/test_cfgreg_i2c_target.sv
module test_cfgreg_i2c_target;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 6;
   localparam int BUSY = 300;
   localparam logic [3:0] PREFIX = 4'b1010;

   logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_drv = 1'b1;
   logic [2:0] strap = 3'b010;
   logic sda_oe, busy, sda_line;
   logic [7:0] ref_code, slope_code;
   logic [1:0] gain_sel;
   int checks = 0, fails = 0, viol = 0;
   logic oe_prev = 1'b0;

   assign sda_line = sda_drv & ~sda_oe;

   cfgreg_i2c_target #(.ADDR_PREFIX(PREFIX), .SYNC_STAGES(2), .BUSY_CYCLES(BUSY)) i_cfgreg_i2c_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
      .strap_i(strap), .ref_code(ref_code), .slope_code(slope_code),
      .gain_sel(gain_sel), .busy(busy));

   always #(CLK_PERIOD/2) clk = ~clk;

   // R11 monitor: the target may only start pulling SDA while SCL is low
   always @(negedge clk) begin
      if (sda_oe && !oe_prev && scl) viol++;
      oe_prev <= sda_oe;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; scl = 1'b1; tick(Q);
      sda_drv = 1'b0; tick(Q);
      scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; tick(Q);
      scl = 1'b1; tick(Q);
      sda_drv = 1'b1; tick(Q);
   endtask

   task automatic stop_measure(output int n);
      sda_drv = 1'b0; tick(Q);
      scl = 1'b1; tick(Q);
      sda_drv = 1'b1;
      n = 0;
      for (int i = 0; i < BUSY + 40; i++) begin
         tick(1);
         if (busy) n++;
         else if (n > 0 || i > 20) break;
      end
   endtask

   task automatic put_bit(input logic b);
      sda_drv = b; tick(Q);
      scl = 1'b1; tick(2*Q);
      scl = 1'b0; tick(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_drv = 1'b1; tick(Q);
      scl = 1'b1; tick(Q);
      b = sda_line; tick(Q);
      scl = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] d);
      logic b;
      for (int i = 0; i < 8; i++) begin
         get_bit(b);
         d = {d[6:0], b};
      end
      put_bit(nack);
   endtask

   function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
      return {PREFIX, s, rd};
   endfunction

   task automatic write_regs(input logic [7:0] p, input logic [7:0] d0, input int cnt,
                             output int busy_n);
      logic a;
      bus_start();
      send_byte(addr_byte(strap, 1'b0), a);
      check(a, "R4 address ack", a, 1);
      send_byte(p, a);
      check(a, "R5 pointer ack", a, 1);
      for (int i = 0; i < cnt; i++) begin
         send_byte(d0 + 8'(i * 8'h33), a);
         check(a, "R5 data ack", a, 1);
      end
      stop_measure(busy_n);
   endtask

   task automatic read_regs(input logic [7:0] p, input int cnt, output logic [7:0] got [4]);
      logic a;
      int bn;
      bus_start();
      send_byte(addr_byte(strap, 1'b0), a);
      send_byte(p, a);
      bus_start();
      send_byte(addr_byte(strap, 1'b1), a);
      check(a, "R7 read address ack", a, 1);
      for (int i = 0; i < cnt; i++) recv_byte(i == cnt - 1, got[i]);
      check(sda_oe == 1'b0, "R7 released after NACK", sda_oe, 0);
      stop_measure(bn);
      check(bn == 0, "R8 no busy after read", bn, 0);
   endtask

   task automatic t_reset();
      check(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);
      check(ref_code == 8'h00 && slope_code == 8'h00, "R10 registers zero",
            {ref_code, slope_code}, 0);
      check(gain_sel == 2'd0, "R10 gain x1", gain_sel, 0);
      check(busy == 1'b0, "R10 busy low", busy, 0);
   endtask

   task automatic t_write_read();
      int bn;
      logic [7:0] got [4];
      write_regs(8'd0, 8'hA5, 2, bn);
      check(ref_code == 8'hA5, "R1 ref_code", ref_code, 8'hA5);
      check(slope_code == 8'hD8, "R1 slope_code after auto-increment R5", slope_code, 8'hD8);
      check(bn == BUSY, "R8 busy length", bn, BUSY);
      read_regs(8'd0, 2, got);
      check(got[0] == 8'hA5, "R3 R7 read byte 0 MSB first", got[0], 8'hA5);
      check(got[1] == 8'hD8, "R7 read auto-increment", got[1], 8'hD8);
   endtask

   task automatic t_gain();
      int bn;
      logic [7:0] got [4];
      logic [7:0] pat [4] = '{8'hA0, 8'h55, 8'hC6, 8'h07};
      logic [1:0] exp [4] = '{2'd0, 2'd1, 2'd1, 2'd2};
      for (int i = 0; i < 4; i++) begin
         write_regs(8'd2, pat[i], 1, bn);
         check(gain_sel == exp[i], "R2 gain decode", gain_sel, exp[i]);
         read_regs(8'd2, 1, got);
         check(got[0] == pat[i], "R2 spare bits stored", got[0], pat[i]);
      end
   endtask

   task automatic t_address();
      logic a;
      int bn;
      logic [7:0] got [4];
      bus_start();
      send_byte(addr_byte(3'b101, 1'b0), a);
      check(!a, "R4 wrong address NACK", a, 0);
      send_byte(8'd0, a);
      send_byte(8'h77, a);
      stop_measure(bn);
      check(ref_code == 8'hA5, "R4 ignored transfer", ref_code, 8'hA5);
      check(bn == 0, "R4 R8 no busy", bn, 0);
      strap = 3'b101;
      write_regs(8'd3, 8'h5A, 1, bn);
      read_regs(8'd3, 1, got);
      check(got[0] == 8'h5A, "R4 new strap address", got[0], 8'h5A);
      strap = 3'b010;
   endtask

   task automatic t_bad_pointer();
      logic a;
      int bn;
      logic [7:0] got [4];
      bus_start();
      send_byte(addr_byte(strap, 1'b0), a);
      send_byte(8'd5, a);
      check(!a, "R6 pointer NACK", a, 0);
      send_byte(8'h99, a);
      check(!a, "R6 data NACK", a, 0);
      stop_measure(bn);
      check(bn == 0, "R8 no busy without stored data", bn, 0);
      bus_start();
      send_byte(addr_byte(strap, 1'b0), a);
      send_byte(8'd4, a);
      send_byte(8'h3C, a);
      check(a, "R5 last register ack", a, 1);
      send_byte(8'hEE, a);
      check(!a, "R6 past end NACK", a, 0);
      stop_measure(bn);
      read_regs(8'd4, 2, got);
      check(got[0] == 8'h3C, "R6 discarded data", got[0], 8'h3C);
      check(got[1] == 8'hFF, "R7 out of range reads FF", got[1], 8'hFF);
   endtask

   task automatic t_busy_ignore();
      logic a;
      int bn;
      logic [7:0] got [4];
      bus_start();
      send_byte(addr_byte(strap, 1'b0), a);
      send_byte(8'd4, a);
      send_byte(8'h11, a);
      bus_stop();
      check(busy == 1'b1, "R8 busy after write", busy, 1);
      bus_start();
      send_byte(addr_byte(strap, 1'b0), a);
      check(!a, "R9 START ignored while busy", a, 0);
      send_byte(8'd4, a);
      send_byte(8'h99, a);
      bus_stop();
      for (int i = 0; i < 3 * BUSY && busy; i++) tick(1);
      read_regs(8'd4, 1, got);
      check(got[0] == 8'h11, "R9 no write while busy", got[0], 8'h11);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      t_reset();
      t_write_read();
      t_gain();
      t_address();
      t_bad_pointer();
      t_busy_ignore();
      check(viol == 0, "R11 sda_oe rose while SCL high", viol, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule